// File: doc/BRIEF.md
# Pipelined Multiply-Accumulator

This block forms the product of two operands and adds it to a running sum on every clock edge at which its clock enable is high. The sum lives in a register that is always present, so the result never leaves the block combinationally. Two further register stages can be chosen when the block is elaborated: one that captures the operands and one that captures the product. Together with the sum register, these give a latency of one, two or three cycles.

Each operand has its own sign-control input, sampled together with the operand. When the control is high, the operand is read as two's complement. When it is low, the operand is read as an unsigned number. The sign travels through the optional stages with its operand, so the sign controls may change every cycle. The sum is ACCW bits wide, with ACCW between WA+WB and WA+WB+16. Typical sizes are a 34-bit sum for 9-bit operands and a 52-bit sum for 18-bit operands. The sum wraps around on overflow.

Top module: `pipelined_mac`

## Requirements
- R1: On every rising clock edge with `ce` high, the sum register takes its previous value plus the product that has reached the end of the multiply path, taken modulo 2^ACCW.
- R2: An operand pair presented with `ce` high appears in `acc_o` after 1 + IN_REG + PIPE_REG enabled edges. The operand register counts as IN_REG and the product register counts as PIPE_REG. The sum register is always present, so the latency is never zero.
- R3: When `a_sgn` is 1, `a_i` is taken as two's complement, and when it is 0, `a_i` is taken as unsigned. `b_sgn` does the same for `b_i`. The product is sign-extended to ACCW bits when it is negative and zero-extended otherwise.
- R4: While `ce` is low, every stage keeps its contents and `acc_o` does not change. Operands presented during those cycles are never added.
- R5: `arst` high sets `acc_o` to zero at once, without waiting for a clock edge. It also empties every optional stage, so a product that was in flight before the clear never reaches the sum.
- R6: The sum wraps modulo 2^ACCW when it overflows, and no saturation is applied. For example, with ACCW = 18, adding 261121 to 261133 gives 260110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable for all stages |
| a_i | input | WA | First operand |
| b_i | input | WB | Second operand |
| a_sgn | input | 1 | 1: `a_i` is two's complement; 0: unsigned |
| b_sgn | input | 1 | 1: `b_i` is two's complement; 0: unsigned |
| acc_o | output | ACCW | Accumulated sum |

## Verification
The hardest situation to reach from the ports is a product stranded inside the pipeline. This happens when the enable drops, or the clear fires, after an operand pair has entered the first stage but before its product has reached the sum. The stimulus presents one known pair, then lowers the enable at once and drives all-ones operands for several cycles, then resumes with zero operands. The sum must grow by exactly the held product and by nothing else. A second sequence raises the clear while a pair is in flight, then runs zero operands for several cycles and expects the sum to stay at zero. Instances with latencies of one, two and three cycles are driven side by side so that each delay can be observed.

// File: rtl/mac_pkg.sv
package mac_pkg;

    // Headroom allowed above the full product width
    localparam int ACC_HEADROOM = 16;

    // Cycles from operand capture to visible sum
    function automatic int mac_latency(bit in_reg, bit pipe_reg);
        return 1 + int'(in_reg) + int'(pipe_reg);
    endfunction

endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage #(
    parameter int WA = 18,
    parameter int WB = 18,
    parameter bit EN = 1'b1
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          ce,
    input  logic [WA-1:0] a_i,
    input  logic [WB-1:0] b_i,
    input  logic          a_sgn_i,
    input  logic          b_sgn_i,
    output logic [WA-1:0] a_o,
    output logic [WB-1:0] b_o,
    output logic          a_sgn_o,
    output logic          b_sgn_o
);

    typedef struct packed {
        logic [WA-1:0] a;
        logic [WB-1:0] b;
        logic          as;
        logic          bs;
    } opnd_t;

    generate
        if (EN) begin : g_reg
            opnd_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (ce) begin
                    st_d.a  = a_i;
                    st_d.b  = b_i;
                    st_d.as = a_sgn_i;
                    st_d.bs = b_sgn_i;
                end
            end

            always_ff @(posedge clk or posedge arst) begin
                if (arst) st_q <= '0;
                else      st_q <= st_d;
            end

            assign a_o     = st_q.a;
            assign b_o     = st_q.b;
            assign a_sgn_o = st_q.as;
            assign b_sgn_o = st_q.bs;
        end else begin : g_bypass
            assign a_o     = a_i;
            assign b_o     = b_i;
            assign a_sgn_o = a_sgn_i;
            assign b_sgn_o = b_sgn_i;
        end
    endgenerate

endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage #(
    parameter int WA   = 18,
    parameter int WB   = 18,
    parameter int ACCW = 52,
    parameter bit EN   = 1'b1
) (
    input  logic            clk,
    input  logic            arst,
    input  logic            ce,
    input  logic [WA-1:0]   a_i,
    input  logic [WB-1:0]   b_i,
    input  logic            a_sgn_i,
    input  logic            b_sgn_i,
    output logic [ACCW-1:0] prod_o
);

    // One extra bit per operand covers both signed and unsigned readings
    localparam int PW = WA + WB + 2;

    typedef struct packed {
        logic [ACCW-1:0] prod;
    } pipe_t;

    logic signed [WA:0]     a_x;
    logic signed [WB:0]     b_x;
    logic signed [PW-1:0]   a_w;
    logic signed [PW-1:0]   b_w;
    logic signed [PW-1:0]   p_full;
    logic        [ACCW-1:0] p_ext;

    always_comb begin
        a_x    = {a_sgn_i & a_i[WA-1], a_i};
        b_x    = {b_sgn_i & b_i[WB-1], b_i};
        a_w    = PW'(a_x);
        b_w    = PW'(b_x);
        p_full = a_w * b_w;
    end

    generate
        if (ACCW > PW) begin : g_widen
            assign p_ext = {{(ACCW-PW){p_full[PW-1]}}, p_full};
        end else if (ACCW == PW) begin : g_same
            assign p_ext = p_full;
        end else begin : g_trim
            assign p_ext = p_full[ACCW-1:0];
        end

        if (EN) begin : g_reg
            pipe_t pp_d, pp_q;

            always_comb begin
                pp_d = pp_q;
                if (ce) pp_d.prod = p_ext;
            end

            always_ff @(posedge clk or posedge arst) begin
                if (arst) pp_q <= '0;
                else      pp_q <= pp_d;
            end

            assign prod_o = pp_q.prod;
        end else begin : g_bypass
            assign prod_o = p_ext;
        end
    endgenerate

endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
    parameter int ACCW = 52
) (
    input  logic            clk,
    input  logic            arst,
    input  logic            ce,
    input  logic [ACCW-1:0] prod_i,
    output logic [ACCW-1:0] acc_o
);

    typedef struct packed {
        logic [ACCW-1:0] sum;
    } acc_t;

    acc_t ac_d, ac_q;

    always_comb begin
        ac_d = ac_q;
        if (ce) ac_d.sum = ac_q.sum + prod_i;   // wraps modulo 2^ACCW
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) ac_q <= '0;
        else      ac_q <= ac_d;
    end

    assign acc_o = ac_q.sum;

endmodule

// File: rtl/pipelined_mac.sv
module pipelined_mac #(
    parameter int WA       = 18,
    parameter int WB       = 18,
    parameter int ACCW     = 52,
    parameter bit IN_REG   = 1'b1,
    parameter bit PIPE_REG = 1'b1
) (
    input  logic            clk,
    input  logic            arst,
    input  logic            ce,
    input  logic [WA-1:0]   a_i,
    input  logic [WB-1:0]   b_i,
    input  logic            a_sgn,
    input  logic            b_sgn,
    output logic [ACCW-1:0] acc_o
);

    localparam int LAT = mac_pkg::mac_latency(IN_REG, PIPE_REG);

    logic [WA-1:0]   a_s;
    logic [WB-1:0]   b_s;
    logic            as_s;
    logic            bs_s;
    logic [ACCW-1:0] prod_w;

    mac_in_stage #(.WA(WA), .WB(WB), .EN(IN_REG)) u_in (
        .clk     (clk),
        .arst    (arst),
        .ce      (ce),
        .a_i     (a_i),
        .b_i     (b_i),
        .a_sgn_i (a_sgn),
        .b_sgn_i (b_sgn),
        .a_o     (a_s),
        .b_o     (b_s),
        .a_sgn_o (as_s),
        .b_sgn_o (bs_s)
    );

    mac_mul_stage #(.WA(WA), .WB(WB), .ACCW(ACCW), .EN(PIPE_REG)) u_mul (
        .clk     (clk),
        .arst    (arst),
        .ce      (ce),
        .a_i     (a_s),
        .b_i     (b_s),
        .a_sgn_i (as_s),
        .b_sgn_i (bs_s),
        .prod_o  (prod_w)
    );

    mac_acc #(.ACCW(ACCW)) u_acc (
        .clk    (clk),
        .arst   (arst),
        .ce     (ce),
        .prod_i (prod_w),
        .acc_o  (acc_o)
    );

endmodule

// File: rtl/pipelined_mac_chk.sv
module pipelined_mac_chk #(
    parameter int WA   = 18,
    parameter int WB   = 18,
    parameter int ACCW = 52,
    parameter int LAT  = 3
) (
    input logic            clk,
    input logic            arst,
    input logic            ce,
    input logic [WA-1:0]   a_i,
    input logic [WB-1:0]   b_i,
    input logic [ACCW-1:0] prod,
    input logic [ACCW-1:0] acc_o
);

    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LAT - 1);

    // Counts consecutive enabled cycles with a zero operand
    logic [CW-1:0] zc_d, zc_q;
    logic          zero_in;

    always_comb begin
        zero_in = (a_i == '0) || (b_i == '0);
        zc_d    = zc_q;
        if (ce) begin
            if (!zero_in)        zc_d = '0;
            else if (zc_q < CMAX) zc_d = zc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) zc_q <= '0;
        else      zc_q <= zc_d;
    end

    p_sum_r1: assert property (@(posedge clk) disable iff (arst)
        ce |=> acc_o == $past(acc_o) + $past(prod));

    p_zero_flush_r2: assert property (@(posedge clk) disable iff (arst)
        (ce && zero_in && zc_q >= CMAX) |=> $stable(acc_o));

    p_hold_r4: assert property (@(posedge clk) disable iff (arst)
        !ce |=> $stable(acc_o));

    always @(posedge clk) begin
        if (arst) begin
            p_clear_r5: assert (acc_o == '0);
        end
    end

endmodule

bind pipelined_mac pipelined_mac_chk #(
    .WA(WA), .WB(WB), .ACCW(ACCW), .LAT(LAT)
) u_chk (
    .clk   (clk),
    .arst  (arst),
    .ce    (ce),
    .a_i   (a_i),
    .b_i   (b_i),
    .prod  (prod_w),
    .acc_o (acc_o)
);

// File: tb/pipelined_mac_bench.sv
`timescale 1ns/1ps
module pipelined_mac_bench;

    localparam int N = 9;

    typedef struct packed {
        logic [17:0] a;
        logic [17:0] b;
        logic        as;
        logic        bs;
        logic [51:0] prod;
    } vec_t;

    // Operands, sign controls and the expected product (R3)
    localparam vec_t VEC [N] = '{
        '{18'h00003, 18'h00005, 1'b0, 1'b0, 52'(64'sd15)},
        '{18'h3FFFE, 18'h00007, 1'b1, 1'b1, 52'(-64'sd14)},
        '{18'h3FFFE, 18'h00002, 1'b0, 1'b0, 52'(64'sd524284)},
        '{18'h3FFFF, 18'h3FFFF, 1'b1, 1'b0, 52'(-64'sd262143)},
        '{18'h3FFFF, 18'h3FFFF, 1'b0, 1'b0, 52'(64'sd68718952449)},
        '{18'h20000, 18'h20000, 1'b1, 1'b1, 52'(64'sd17179869184)},
        '{18'h1FFFF, 18'h20000, 1'b1, 1'b1, 52'(-64'sd17179738112)},
        '{18'h20000, 18'h3FFFF, 1'b1, 1'b0, 52'(-64'sd34359607296)},
        '{18'h00010, 18'h3FFF0, 1'b0, 1'b1, 52'(-64'sd256)}
    };

    logic        clk = 1'b0;
    logic        arst = 1'b1;
    logic        ce = 1'b0;
    logic [17:0] a = '0, b = '0;
    logic        as = 1'b0, bs = 1'b0;
    logic [51:0] acc3, acc2;

    logic        ce9 = 1'b0;
    logic [8:0]  a9 = '0, b9 = '0;
    logic        as9 = 1'b0, bs9 = 1'b0;
    logic [17:0] acc1;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pipelined_mac u_pipelined_mac (
        .clk(clk), .arst(arst), .ce(ce), .a_i(a), .b_i(b),
        .a_sgn(as), .b_sgn(bs), .acc_o(acc3)
    );

    pipelined_mac #(.IN_REG(1'b1), .PIPE_REG(1'b0)) u_lat2 (
        .clk(clk), .arst(arst), .ce(ce), .a_i(a), .b_i(b),
        .a_sgn(as), .b_sgn(bs), .acc_o(acc2)
    );

    pipelined_mac #(.WA(9), .WB(9), .ACCW(18), .IN_REG(1'b0), .PIPE_REG(1'b0)) u_lat1 (
        .clk(clk), .arst(arst), .ce(ce9), .a_i(a9), .b_i(b9),
        .a_sgn(as9), .b_sgn(bs9), .acc_o(acc1)
    );

    task automatic check(input string tag, input logic [51:0] act, input logic [51:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [17:0] va, input logic [17:0] vb, input logic sa, input logic sb);
        a = va; b = vb; as = sa; bs = sb;
    endtask

    initial begin
        longint cum [N];
        logic [51:0] pre3, pre2;
        longint run;

        run = 0;
        for (int i = 0; i < N; i++) begin
            run    = run + longint'($signed(VEC[i].prod));
            cum[i] = run;
        end

        repeat (3) @(negedge clk);
        check("R5 reset lat3", acc3, '0);
        check("R5 reset lat2", acc2, '0);
        check("R5 reset lat1", 52'(acc1), '0);
        arst = 1'b0;

        // Vector table: back-to-back products, R1 R2 R3 R6
        for (int k = 0; k < N + 3; k++) begin
            @(negedge clk);
            if (k >= 3) check("R1 R2 R3 R6 lat3 stream", acc3, cum[k-3][51:0]);
            if (k >= 2 && k < N + 2) check("R1 R2 R3 R6 lat2 stream", acc2, cum[k-2][51:0]);
            ce = 1'b1;
            if (k < N) drive(VEC[k].a, VEC[k].b, VEC[k].as, VEC[k].bs);
            else       drive('0, '0, 1'b0, 1'b0);
        end

        // R4: product in flight while enable is low
        pre3 = acc3; pre2 = acc2;
        drive(18'd100, 18'd3, 1'b0, 1'b0);
        @(negedge clk);
        ce = 1'b0;
        drive(18'h3FFFF, 18'h3FFFF, 1'b1, 1'b0);
        repeat (4) begin
            @(negedge clk);
            check("R4 hold lat3", acc3, pre3);
            check("R4 hold lat2", acc2, pre2);
        end
        ce = 1'b1;
        drive('0, '0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R4 resume lat3", acc3, pre3 + 52'd300);
        check("R4 resume lat2", acc2, pre2 + 52'd300);

        // R5: asynchronous clear with a product in flight
        drive(18'd5, 18'd5, 1'b0, 1'b0);
        @(negedge clk);
        drive('0, '0, 1'b0, 1'b0);
        arst = 1'b1;
        #1;
        check("R5 async clear lat3", acc3, '0);
        check("R5 async clear lat2", acc2, '0);
        @(negedge clk);
        arst = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 flushed lat3", acc3, '0);
        check("R5 flushed lat2", acc2, '0);

        // Latency one, minimum-width sum
        ce9 = 1'b1; a9 = 9'd3; b9 = 9'd4;
        @(negedge clk);
        check("R2 lat1 one cycle", 52'(acc1), 52'd12);
        a9 = 9'h1FF; b9 = 9'h1FF;
        @(negedge clk);
        check("R6 lat1 first add", 52'(acc1), 52'd261133);
        @(negedge clk);
        check("R6 lat1 wrap", 52'(acc1), 52'd260110);
        a9 = 9'h100; as9 = 1'b1; b9 = 9'h1FF; bs9 = 1'b0;
        @(negedge clk);
        check("R3 lat1 signed x unsigned", 52'(acc1), 52'd129294);
        bs9 = 1'b1;
        @(negedge clk);
        check("R3 lat1 signed x signed", 52'(acc1), 52'd129550);
        ce9 = 1'b0; a9 = 9'd7;
        @(negedge clk);
        check("R4 lat1 hold", 52'(acc1), 52'd129550);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule